// File: doc/BRIEF.md
# Configuration Register Slave for a Spread-Spectrum Clock Generator

This block is the two-wire serial slave that holds the small set of control registers of a spread-spectrum clock generator. The master reaches it at one 8-bit address for writes (0xD4) and one for reads (0xD5). The command byte picks one of two access styles. Bit 7 clear selects a block transfer, which carries a byte count and always starts at register 0. Bit 7 set selects a single-byte transfer at the offset held in bits 6:0. Data moves MSB first. The slave acknowledges by pulling SDA low through an output enable, and it changes SDA only while SCL is low.

The register file drives the generator's control outputs. Register 0 carries the hardware/software select, the spread enable, the frequency select and the four spread select bits. Register 1 carries the clock-output enable and a two-bit spread-range select. Register 6 is a fixed identification byte. In hardware mode the spread select follows three pins, and the frequency follows a select pin latched during reset. In software mode both come from register 0.

Top module: `sscg_cfg_slave`

## Requirements
- R1: An address byte of 0xD4 (write) or 0xD5 (read) is acknowledged. Any other address byte is not acknowledged, and the slave leaves SDA released until the next START.
- R2: A command byte with bit 7 = 1 is acknowledged and selects a single-byte access at offset bits 6:0. A command of 0x00 is acknowledged and selects a block access. A command with bit 7 = 0 and nonzero bits 6:0 is not acknowledged.
- R3: A block write sends a count byte and then data bytes. The data bytes go to register 0, 1, 2 and upward. Each data byte is acknowledged while the count is not used up, and the first byte beyond the count is not acknowledged. A STOP after any complete byte keeps the bytes already written.
- R4: A block read (0xD4, 0x00, repeated START, 0xD5) returns the count 7 and then registers 0, 1, 2 and upward, MSB first. It continues while the master acknowledges.
- R5: A byte write stores exactly one data byte at the command offset, and a second data byte is not acknowledged. A byte read (0xD4, 0x80|offset, repeated START, 0xD5) returns the register at that offset.
- R6: After reset, register 0 = {0, S1, S2, S3, F, 0, 1, 0} (bit 7 down to bit 0). Here S1 = ss_pin_i[0], S2 = ss_pin_i[1], S3 = ss_pin_i[2], and F = fsel_pin_i during reset. Register 1 = 0x04, registers 2 to 5 read 0x00, and register 6 reads 0x08.
- R7: Writes are ignored for register 0 bit 2, register 1 bits 7:3, registers 2 to 5 and register 6.
- R8: With register 0 bit 0 = 0, spread_sel_o = {ss_pin_i, 0}, and freq_sel_o holds the fsel_pin_i level captured in reset. With bit 0 = 1, spread_sel_o = {r0[4], r0[5], r0[6], r0[7]} and freq_sel_o = r0[3].
- R9: spread_en_o = register 0 bit 1, clk_en_o = register 1 bit 2, and cp_sel_o = register 1 bits 1:0.
- R10: A STOP returns the slave to idle with SDA released, including a STOP in the middle of a byte. A START in any state restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; frequency pin captured while low |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ss_pin_i | input | 3 | Spread select pins {S3,S2,S1} |
| fsel_pin_i | input | 1 | Frequency select pin, sampled in reset |
| spread_sel_o | output | 4 | Effective spread select {S3,S2,S1,S0} |
| freq_sel_o | output | 1 | Effective frequency select (1 = higher rate) |
| spread_en_o | output | 1 | Spread modulation enable |
| clk_en_o | output | 1 | Differential clock output enable |
| cp_sel_o | output | 2 | Spread range select |

## Verification
Two things land in the same clock cycle. A register write commits on the SCL fall that starts the acknowledge of a data byte, and that same write can flip the hardware/software bit. The control multiplexer then changes source in the very cycle the acknowledge begins. The bench provokes this with block and byte writes to register 0 that enter and leave software mode while the pins hold values different from the register fields. It judges the spread select, frequency and enable outputs once the transfer ends, and the frequency must come back to the reset-latched level, not the live pin.

// File: rtl/sscg_cfg_pkg.sv
package sscg_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_st_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_COUNT,
        K_DATA
    } rx_kind_e;

endpackage

// File: rtl/sscg_bus_sync.sv
module sscg_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_ch;
        logic [STAGES-1:0] sda_ch;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.scl_ch[0] = scl_i;
        d.sda_ch[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            d.scl_ch[i] = q.scl_ch[i-1];
            d.sda_ch[i] = q.sda_ch[i-1];
        end
        d.scl_p = q.scl_ch[STAGES-1];
        d.sda_p = q.sda_ch[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_s     = q.scl_ch[STAGES-1];
    assign sda_s     = q.sda_ch[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_det = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_det  = scl_s & q.scl_p & ~q.sda_p & sda_s;

endmodule

// File: rtl/sscg_bus_fsm.sv
module sscg_bus_fsm
    import sscg_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6A,
    parameter int         NREGS    = 7,
    parameter int         PTR_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data_i,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [7:0]       wr_data_o,
    output logic             sda_oe_o
);

    localparam logic [7:0] COUNT_VAL = 8'(NREGS);

    typedef struct packed {
        bus_st_e          st;
        rx_kind_e         kind;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic             oe;
        logic [PTR_W-1:0] ptr;
        logic [7:0]       remain;
        logic [7:0]       cmd;
        logic             send_cnt;
        logic             rd_pend;
        logic             mack;
    } fsm_t;

    fsm_t q, d;
    logic [7:0] tx_byte;
    logic       wr_en;

    assign tx_byte = q.send_cnt ? COUNT_VAL : rd_data_i;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_det) begin
            d.st     = ST_RX;
            d.kind   = K_ADDR;
            d.bitcnt = 4'd0;
            d.oe     = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.st = ST_IDLE;
                        case (q.kind)
                            K_ADDR: begin
                                if (q.shreg[7:1] == DEV_ADDR) begin
                                    d.st      = ST_RX_ACK;
                                    d.oe      = 1'b1;
                                    d.rd_pend = q.shreg[0];
                                    d.kind    = K_CMD;
                                    if (q.shreg[0]) begin
                                        d.send_cnt = ~q.cmd[7];
                                        d.ptr      = q.cmd[7] ? PTR_W'(q.cmd[6:0]) : '0;
                                    end
                                end
                            end
                            K_CMD: begin
                                if (q.shreg[7] || q.shreg[6:0] == 7'd0) begin
                                    d.st  = ST_RX_ACK;
                                    d.oe  = 1'b1;
                                    d.cmd = q.shreg;
                                    if (q.shreg[7]) begin
                                        d.ptr    = PTR_W'(q.shreg[6:0]);
                                        d.remain = 8'd1;
                                        d.kind   = K_DATA;
                                    end else begin
                                        d.ptr  = '0;
                                        d.kind = K_COUNT;
                                    end
                                end
                            end
                            K_COUNT: begin
                                d.st     = ST_RX_ACK;
                                d.oe     = 1'b1;
                                d.remain = q.shreg;
                                d.kind   = K_DATA;
                            end
                            default: begin
                                if (q.remain != 8'd0) begin
                                    d.st     = ST_RX_ACK;
                                    d.oe     = 1'b1;
                                    wr_en    = 1'b1;
                                    d.remain = q.remain - 8'd1;
                                    d.ptr    = q.ptr + PTR_W'(1);
                                end
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        if (q.rd_pend) begin
                            d.st       = ST_TX;
                            d.shreg    = tx_byte;
                            d.oe       = ~tx_byte[7];
                            d.bitcnt   = 4'd0;
                            d.send_cnt = 1'b0;
                            if (!q.send_cnt) d.ptr = q.ptr + PTR_W'(1);
                        end else begin
                            d.st     = ST_RX;
                            d.bitcnt = 4'd0;
                            d.oe     = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.st   = ST_TX_ACK;
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st       = ST_TX;
                            d.shreg    = tx_byte;
                            d.oe       = ~tx_byte[7];
                            d.bitcnt   = 4'd0;
                            d.send_cnt = 1'b0;
                            if (!q.send_cnt) d.ptr = q.ptr + PTR_W'(1);
                        end else begin
                            d.st = ST_IDLE;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_ADDR;
        end else begin
            q <= d;
        end
    end

    assign rd_ptr_o  = q.ptr;
    assign wr_en_o   = wr_en;
    assign wr_ptr_o  = q.ptr;
    assign wr_data_o = q.shreg;
    assign sda_oe_o  = q.oe;

endmodule

// File: rtl/sscg_cfg_regs.sv
module sscg_cfg_regs #(
    parameter int         NREGS  = 7,
    parameter int         PTR_W  = 7,
    parameter int         PIN_W  = 3,
    parameter logic [7:0] ID_VAL = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] ss_pin_i,
    input  logic             fsel_pin_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output logic [7:0]       rd_data_o,
    output logic             sw_mode_o,
    output logic [PIN_W:0]   spread_sel_o,
    output logic             freq_sel_o,
    output logic             spread_en_o,
    output logic             clk_en_o,
    output logic [1:0]       cp_sel_o
);

    localparam logic [7:0]       R0_WMASK = 8'hFB;
    localparam logic [7:0]       R1_WMASK = 8'h07;
    localparam logic [PTR_W-1:0] ID_IDX   = PTR_W'(NREGS - 1);

    typedef struct packed {
        logic [7:0] r0;
        logic [7:0] r1;
        logic       fsel_lat;
    } regs_t;

    regs_t q, d;
    logic [PIN_W:0] sw_sel;

    always_comb begin
        d = q;
        if (wr_en_i) begin
            if (wr_ptr_i == PTR_W'(0)) d.r0 = wr_data_i & R0_WMASK;
            if (wr_ptr_i == PTR_W'(1)) d.r1 = wr_data_i & R1_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.r0       <= {1'b0, ss_pin_i[0], ss_pin_i[1], ss_pin_i[2], fsel_pin_i, 3'b010};
            q.r1       <= 8'h04;
            q.fsel_lat <= fsel_pin_i;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (rd_ptr_i == PTR_W'(0))      rd_data_o = q.r0;
        else if (rd_ptr_i == PTR_W'(1)) rd_data_o = q.r1;
        else if (rd_ptr_i == ID_IDX)    rd_data_o = ID_VAL;
        else                            rd_data_o = 8'h00;
    end

    genvar g;
    generate
        for (g = 0; g <= PIN_W; g++) begin : g_sel
            assign sw_sel[g] = q.r0[7-g];
        end
    endgenerate

    assign sw_mode_o    = q.r0[0];
    assign spread_sel_o = q.r0[0] ? sw_sel : {ss_pin_i, 1'b0};
    assign freq_sel_o   = q.r0[0] ? q.r0[3] : q.fsel_lat;
    assign spread_en_o  = q.r0[1];
    assign clk_en_o     = q.r1[2];
    assign cp_sel_o     = q.r1[1:0];

endmodule

// File: rtl/sscg_cfg_slave.sv
module sscg_cfg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter int         SYNC_STAGES = 2,
    parameter int         NREGS       = 7,
    parameter logic [7:0] ID_VAL      = 8'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] ss_pin_i,
    input  logic       fsel_pin_i,
    output logic [3:0] spread_sel_o,
    output logic       freq_sel_o,
    output logic       spread_en_o,
    output logic       clk_en_o,
    output logic [1:0] cp_sel_o
);

    localparam int PTR_W = 7;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       rd_data, wr_data;
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             reg_wr, sw_mode;

    sscg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    sscg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data_i (rd_data),
        .rd_ptr_o  (rd_ptr),
        .wr_en_o   (reg_wr),
        .wr_ptr_o  (wr_ptr),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    sscg_cfg_regs #(.NREGS(NREGS), .PTR_W(PTR_W), .PIN_W(3), .ID_VAL(ID_VAL)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ss_pin_i     (ss_pin_i),
        .fsel_pin_i   (fsel_pin_i),
        .wr_en_i      (reg_wr),
        .wr_ptr_i     (wr_ptr),
        .wr_data_i    (wr_data),
        .rd_ptr_i     (rd_ptr),
        .rd_data_o    (rd_data),
        .sw_mode_o    (sw_mode),
        .spread_sel_o (spread_sel_o),
        .freq_sel_o   (freq_sel_o),
        .spread_en_o  (spread_en_o),
        .clk_en_o     (clk_en_o),
        .cp_sel_o     (cp_sel_o)
    );

endmodule

// File: rtl/sscg_cfg_chk.sv
module sscg_cfg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       sda_oe_o,
    input logic       reg_wr,
    input logic       sw_mode,
    input logic       freq_sel_o,
    input logic       spread_en_o,
    input logic       clk_en_o,
    input logic [1:0] cp_sel_o
);

    // R10
    sda_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

    // R10
    stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R3
    write_on_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !scl_s);

    // R8
    hw_freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_mode && $past(!sw_mode)) |-> $stable(freq_sel_o));

    // R9
    ctrl_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr) |-> ($stable(clk_en_o) && $stable(cp_sel_o) && $stable(spread_en_o)));

endmodule

bind sscg_cfg_slave sscg_cfg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .stop_det    (stop_det),
    .sda_oe_o    (sda_oe_o),
    .reg_wr      (reg_wr),
    .sw_mode     (sw_mode),
    .freq_sel_o  (freq_sel_o),
    .spread_en_o (spread_en_o),
    .clk_en_o    (clk_en_o),
    .cp_sel_o    (cp_sel_o)
);

// File: tb/sscg_cfg_slave_tb.sv
`timescale 1ns/1ps
module sscg_cfg_slave_tb;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [2:0] ss_pin = 3'b101;
    logic       fsel_pin = 1'b1;
    logic [3:0] spread_sel;
    logic       freq_sel, spread_en, clk_en;
    logic [1:0] cp_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_val[$];
    string      exp_tag[$];
    logic [7:0] act_val[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    sscg_cfg_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .ss_pin_i     (ss_pin),
        .fsel_pin_i   (fsel_pin),
        .spread_sel_o (spread_sel),
        .freq_sel_o   (freq_sel),
        .spread_en_o  (spread_en),
        .clk_en_o     (clk_en),
        .cp_sel_o     (cp_sel)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_val.size() > 0 && exp_val.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_val.pop_front();
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                chk(a == e, t, a, e);
            end
        end
    end

    task automatic wq(); repeat (Q) @(posedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    // send a byte; expected ack bit: 0 = acknowledged, 1 = not acknowledged
    task automatic send(input logic [7:0] v, input logic exp_nack, input string tag);
        logic a;
        exp_val.push_back({7'd0, exp_nack});
        exp_tag.push_back(tag);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        act_val.push_back({7'd0, a});
    endtask

    task automatic recv(input logic [7:0] e, input logic m_ack, input string tag);
        logic [7:0] v;
        logic b;
        exp_val.push_back(e);
        exp_tag.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~m_ack);
        act_val.push_back(v);
    endtask

    task automatic byte_wr(input logic [6:0] off, input logic [7:0] v, input string tag);
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        send({1'b1, off}, 1'b0, "R2 byte command");
        send(v, 1'b0, tag);
        bus_stop();
    endtask

    task automatic byte_rd(input logic [6:0] off, input logic [7:0] e, input string tag);
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        send({1'b1, off}, 1'b0, "R2 byte command");
        bus_start();
        send(8'hD5, 1'b0, "R1 read address");
        recv(e, 1'b0, tag);
        bus_stop();
    endtask

    task automatic out_chk(input logic [3:0] sel, input logic fq, input logic se,
                           input logic ce, input logic [1:0] cp, input string tag);
        @(negedge clk);
        chk(spread_sel == sel, {tag, " spread_sel"}, {4'd0, spread_sel}, {4'd0, sel});
        chk(freq_sel == fq, {tag, " freq_sel"}, {7'd0, freq_sel}, {7'd0, fq});
        chk(spread_en == se, {tag, " spread_en"}, {7'd0, spread_en}, {7'd0, se});
        chk(clk_en == ce, {tag, " clk_en"}, {7'd0, clk_en}, {7'd0, ce});
        chk(cp_sel == cp, {tag, " cp_sel"}, {6'd0, cp_sel}, {6'd0, cp});
    endtask

    task automatic finish_run();
        repeat (20) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=%h exp=%h", 8'h00, 8'h01);
            finish_run();
        end
    end

    logic [7:0] blk_exp [7];

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        fsel_pin = 1'b0;
        repeat (10) @(posedge clk);

        // R6 R8 R9: reset outputs, pins S3..S1 = 101, latched frequency 1
        @(negedge clk);
        chk(sda_oe == 1'b0, "R10 sda released after reset", {7'd0, sda_oe}, 8'h00);
        out_chk(4'b1010, 1'b1, 1'b1, 1'b1, 2'b00, "R6 R8 R9 reset");

        // R4 R6: block read of defaults
        blk_exp = '{8'h5A, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h08};
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        send(8'h00, 1'b0, "R2 block command");
        bus_start();
        send(8'hD5, 1'b0, "R1 read address");
        recv(8'h07, 1'b1, "R4 block count");
        for (int i = 0; i < 7; i++) recv(blk_exp[i], i != 6, "R4 R6 block read data");
        bus_stop();

        // R8: hardware mode follows live pins, frequency stays latched
        ss_pin = 3'b011;
        out_chk(4'b0110, 1'b1, 1'b1, 1'b1, 2'b00, "R8 hw pins");

        // R1: foreign address ignored, slave stays silent
        bus_start();
        send(8'hA4, 1'b1, "R1 foreign address nack");
        send(8'h80, 1'b1, "R1 silent after mismatch");
        bus_stop();

        // R2: block command with nonzero low bits
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        send(8'h05, 1'b1, "R2 bad block command nack");
        bus_stop();

        // R3 R7: block write count 2, reserved bits set, third byte refused
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        send(8'h00, 1'b0, "R2 block command");
        send(8'h02, 1'b0, "R3 count ack");
        send(8'hB5, 1'b0, "R3 data0 ack");
        send(8'hFA, 1'b0, "R3 data1 ack");
        send(8'h33, 1'b1, "R3 beyond count nack");
        bus_stop();
        out_chk(4'b1101, 1'b0, 1'b0, 1'b0, 2'b10, "R8 R9 sw mode");

        // R5 R7: byte reads of written and masked registers
        byte_rd(7'd0, 8'hB1, "R5 R7 reg0 readback");
        byte_rd(7'd1, 8'h02, "R5 R7 reg1 readback");

        // R7: identification and reserved registers ignore writes
        byte_wr(7'd6, 8'h55, "R5 data ack id reg");
        byte_rd(7'd6, 8'h08, "R7 id unchanged");
        byte_wr(7'd3, 8'hFF, "R5 data ack reserved reg");
        byte_rd(7'd3, 8'h00, "R7 reserved reg reads zero");

        // R5 R9: byte write accepts one data byte only
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        send(8'h81, 1'b0, "R2 byte command");
        send(8'h07, 1'b0, "R5 single data ack");
        send(8'h00, 1'b1, "R5 second data nack");
        bus_stop();
        out_chk(4'b1101, 1'b0, 1'b0, 1'b1, 2'b11, "R9 reg1 fields");

        // R3: STOP after one byte of a longer block keeps it; back to hw mode
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        send(8'h00, 1'b0, "R2 block command");
        send(8'h07, 1'b0, "R3 count ack");
        send(8'h00, 1'b0, "R3 data0 ack");
        bus_stop();
        out_chk(4'b0110, 1'b1, 1'b0, 1'b1, 2'b11, "R3 R8 early stop hw mode");

        // R10: STOP in the middle of a byte, then a normal transfer
        bus_start();
        send(8'hD4, 1'b0, "R1 write address");
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        @(negedge clk);
        chk(sda_oe == 1'b0, "R10 released after mid-byte stop", {7'd0, sda_oe}, 8'h00);
        byte_rd(7'd1, 8'h07, "R10 R5 transfer after abort");

        while (act_val.size() > 0) @(posedge clk);
        repeat (5) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule